// File: doc/BRIEF.md
# Two-Pin Scan Packet Adapter

This block sits on the target side of a reduced-pin debug link. The link has two pins: a clock and one bidirectional data line. The block turns that link into the four conventional test-port signals of an internal core: test clock, mode select, serial data in and serial data out. The host sends packets of three bit slots on the data line.

- The first slot carries the core's serial input, complemented.
- The second slot carries the mode-select value.
- In the third slot the host releases the line and the adapter drives the core's serial output onto it.

Each packet stands for exactly one four-wire test clock cycle. The adapter therefore produces one core clock pulse per packet.

All slot bits are taken on the rising edge of the link clock. The adapter launches its return bit on the falling edge just before the return slot. Mode and data reach the core at least one link cycle before the core clock rises. The core's output settles after the core clock falls, one packet ahead of the slot that returns it.

Top module: `twopin_scan_adapter`

## Requirements
- R1: While `rst_n` is low, the adapter holds `core_clk` at 0, `lnk_data_oe` at 0, `core_mode` at 1 and `core_din` at 0. After release, the first rising edge of `lnk_clk` takes slot 0.
- R2: The bit on `lnk_data_i` at the rising edge that closes slot 0 appears complemented on `core_din` after that edge.
- R3: The bit on `lnk_data_i` at the rising edge that closes slot 1 appears unchanged on `core_mode` after that edge.
- R4: Each three-slot packet gives exactly one `core_clk` pulse. The pulse rises at the edge that closes slot 2 and falls at the next rising edge of `lnk_clk`.
- R5: `lnk_data_oe` is 1 from the falling edge that ends slot 1 until the falling edge that ends slot 2, and 0 at all other times.
- R6: While `lnk_data_oe` is 1, `lnk_data_o` equals the value that `core_dout` had at the falling edge that launched it.
- R7: The level of `lnk_data_i` during slot 2 changes neither `core_din` nor `core_mode`.
- R8: `core_din` and `core_mode` do not change at the rising edge of `core_clk`, nor in the link cycle before it.
- R9: Pulling `rst_n` low in the middle of a packet drops that packet without a `core_clk` pulse. The next packet after release starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lnk_clk | input | 1 | Link clock from the host; all slot bits are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_data_i | input | 1 | Data line as seen by the target (host-driven in slots 0 and 1) |
| lnk_data_o | output | 1 | Return bit driven onto the data line during slot 2 |
| lnk_data_oe | output | 1 | Output enable for the data line, high only for slot 2 |
| core_clk | output | 1 | Generated test clock for the internal core |
| core_mode | output | 1 | Mode-select level for the internal core |
| core_din | output | 1 | Serial data into the internal core |
| core_dout | input | 1 | Serial data out of the internal core |

## Verification
Two things happen on the link edge that closes slot 2. The host takes the returned bit, and the core clock rises. The next rising edge also carries two events: the core clock falls and a new data-in bit is captured. The bench has a 4-bit shift-register core that updates its output on the falling core clock. It sends long runs of shift packets whose data bits differ from the bit coming back. A wrong edge ordering would return the new bit instead of the one captured four shifts earlier. Each returned bit is compared against the pattern four shifting packets back. Hold packets, where mode is 1, are mixed in so that this offset counts only real shifts.

// File: rtl/tpsa_pkg.sv
// Shared definitions for the two-pin scan packet adapter.
// Assumes a fixed three-slot packet: complemented data, mode, return bit.
package tpsa_pkg;
    localparam int SLOT_W = 2;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_DATA = 2'd0,   // host drives complemented core data
        SLOT_MODE = 2'd1,   // host drives mode select
        SLOT_RET  = 2'd2    // target drives core output
    } slot_e;
endpackage

// File: rtl/tpsa_slot_ctr.sv
// Packet position tracker. It holds the slot whose bit will be taken at
// the next rising link edge. Assumes the host never skips a slot.
module tpsa_slot_ctr
    import tpsa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);
    // advance through the three slots, wrapping after the return slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= SLOT_DATA;
        end else begin
            unique case (slot)
                SLOT_DATA: slot <= SLOT_MODE;
                SLOT_MODE: slot <= SLOT_RET;
                default:   slot <= SLOT_DATA;
            endcase
        end
    end
endmodule

// File: rtl/tpsa_capture.sv
// Takes the host-driven slot bits and forms the core-side controls.
// The data bit arrives complemented. The core clock is high for the one
// link cycle after the return slot. Mode and data are already stable
// by then.
module tpsa_capture
    import tpsa_pkg::*;
#(
    parameter logic MODE_RST = 1'b1,   // mode level held during reset
    parameter logic DIN_RST  = 1'b0    // data level held during reset
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_e slot,
    input  logic  bit_i,
    output logic  core_din,
    output logic  core_mode,
    output logic  core_clk
);
    // latch slot bits and raise the core clock once per packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_din  <= DIN_RST;
            core_mode <= MODE_RST;
            core_clk  <= 1'b0;
        end else begin
            core_clk <= (slot == SLOT_RET);
            if (slot == SLOT_DATA) core_din  <= ~bit_i;
            if (slot == SLOT_MODE) core_mode <= bit_i;
        end
    end
endmodule

// File: rtl/tpsa_return.sv
// Return-bit launcher. It works on the falling link edge so that the
// bit and its enable are settled half a cycle before the host samples
// them. Assumes core_dout is stable between core clock falling edges.
module tpsa_return
    import tpsa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_e slot,
    input  logic  core_dout,
    output logic  drv_o,
    output logic  drv_oe
);
    // enable the driver only across the return slot and copy the core bit
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            drv_o  <= 1'b0;
            drv_oe <= 1'b0;
        end else begin
            drv_oe <= (slot == SLOT_RET);
            drv_o  <= (slot == SLOT_RET) ? core_dout : 1'b0;
        end
    end
endmodule

// File: rtl/twopin_scan_adapter.sv
// Target-side adapter from a two-pin packet link to a four-wire core test
// port. One three-slot packet gives one core clock cycle. Assumes the
// pad's tristate buffer is controlled by lnk_data_oe.
module twopin_scan_adapter
    import tpsa_pkg::*;
(
    input  logic lnk_clk,
    input  logic rst_n,
    input  logic lnk_data_i,
    output logic lnk_data_o,
    output logic lnk_data_oe,
    output logic core_clk,
    output logic core_mode,
    output logic core_din,
    input  logic core_dout
);
    slot_e slot;

    tpsa_slot_ctr u_ctr (
        .clk   (lnk_clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    tpsa_capture #(
        .MODE_RST (1'b1),
        .DIN_RST  (1'b0)
    ) u_cap (
        .clk       (lnk_clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .bit_i     (lnk_data_i),
        .core_din  (core_din),
        .core_mode (core_mode),
        .core_clk  (core_clk)
    );

    tpsa_return u_ret (
        .clk       (lnk_clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .core_dout (core_dout),
        .drv_o     (lnk_data_o),
        .drv_oe    (lnk_data_oe)
    );
endmodule

// File: rtl/tpsa_chk.sv
// Temporal checks on the adapter's ports, attached by bind.
module tpsa_chk (
    input logic clk,
    input logic rst_n,
    input logic core_clk,
    input logic core_din,
    input logic core_mode,
    input logic core_dout,
    input logic lnk_data_o,
    input logic lnk_data_oe
);
    // R4
    core_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk |=> !core_clk);

    // R8
    core_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk) |-> ($stable(core_din) && $stable(core_mode)));

    // R5
    ret_then_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_data_oe |=> core_clk);

    // R5
    oe_one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_data_oe |=> !lnk_data_oe);

    // R6
    ret_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_data_oe |-> (lnk_data_o == core_dout));
endmodule

bind twopin_scan_adapter tpsa_chk u_chk (
    .clk         (lnk_clk),
    .rst_n       (rst_n),
    .core_clk    (core_clk),
    .core_din    (core_din),
    .core_mode   (core_mode),
    .core_dout   (core_dout),
    .lnk_data_o  (lnk_data_o),
    .lnk_data_oe (lnk_data_oe)
);

// File: tb/twopin_scan_adapter_test.sv
`timescale 1ns/1ps
module twopin_scan_adapter_test;
    localparam real HALF = 4.0;   // 125 MHz link clock

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lnk_data_i = 1'b0;
    logic lnk_data_o, lnk_data_oe, core_clk, core_mode, core_din;
    logic core_dout = 1'b0;
    logic [3:0] core_sr = 4'd0;
    logic [255:0] hist = '0;
    int shifts = 0;
    int rises = 0;
    int checks = 0;
    int errors = 0;

    always #(HALF) clk = ~clk;

    twopin_scan_adapter uut (
        .lnk_clk     (clk),
        .rst_n       (rst_n),
        .lnk_data_i  (lnk_data_i),
        .lnk_data_o  (lnk_data_o),
        .lnk_data_oe (lnk_data_oe),
        .core_clk    (core_clk),
        .core_mode   (core_mode),
        .core_din    (core_din),
        .core_dout   (core_dout)
    );

    // toy core: shift on rising clock when mode is 0, output on falling clock
    always @(posedge core_clk) begin
        rises <= rises + 1;
        if (!core_mode) core_sr <= {core_din, core_sr[3:1]};
    end
    always @(negedge core_clk) core_dout <= core_sr[0];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // one packet; entered at negedge+1 of the slot-0 period, returns at the next one
    task automatic pkt(input logic di, input logic tms, input logic junk);
        logic exp_tdo;
        int r0;
        exp_tdo = (shifts >= 4) ? hist[shifts-4] : 1'b0;
        r0 = rises;
        chk("R5 oe low in slot0", {31'd0, lnk_data_oe}, 0);
        lnk_data_i = ~di;
        @(negedge clk); #1;
        chk("R2 core_din", {31'd0, core_din}, {31'd0, di});
        chk("R4 core_clk low", {31'd0, core_clk}, 0);
        lnk_data_i = tms;
        @(negedge clk); #1;
        chk("R3 core_mode", {31'd0, core_mode}, {31'd0, tms});
        chk("R5 oe high in slot2", {31'd0, lnk_data_oe}, 1);
        chk("R6 return bit", {31'd0, lnk_data_o}, {31'd0, exp_tdo});
        lnk_data_i = junk;
        @(negedge clk); #1;
        chk("R4 core_clk high", {31'd0, core_clk}, 1);
        chk("R4 one pulse", rises, r0 + 1);
        chk("R7 din kept", {31'd0, core_din}, {31'd0, di});
        chk("R7 mode kept", {31'd0, core_mode}, {31'd0, tms});
        if (!tms) begin
            hist[shifts] = di;
            shifts++;
        end
    endtask

    initial begin
        #(HALF * 2.0 * 100000.0);
        errors++;
        checks++;
        $display("FAIL R4 watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 core_clk", {31'd0, core_clk}, 0);
        chk("R1 oe", {31'd0, lnk_data_oe}, 0);
        chk("R1 mode", {31'd0, core_mode}, 1);
        chk("R1 din", {31'd0, core_din}, 0);
        rst_n = 1'b1;
        // R2 R3 R7: every combination of data, mode and slot-2 junk
        for (int c = 0; c < 8; c++) pkt(c[0], c[1], c[2]);
        // R6: long shift run with holds mixed in
        for (int i = 0; i < 40; i++) begin
            logic b;
            b = ((i * 37 + 5) >> 2) & 1;
            pkt(b, (i % 5) == 4, ~b);
        end
        // R9: reset in the middle of a packet
        lnk_data_i = 1'b0;
        @(negedge clk); #1;
        rst_n = 1'b0;
        begin
            int r0;
            r0 = rises;
            @(negedge clk); #1;
            @(negedge clk); #1;
            chk("R9 oe", {31'd0, lnk_data_oe}, 0);
            chk("R9 core_clk", {31'd0, core_clk}, 0);
            chk("R9 mode", {31'd0, core_mode}, 1);
            chk("R9 no pulse", rises, r0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) pkt((i % 3) == 0, 1'b0, i[0]);
        finish_run();
    end
endmodule